// File: doc/BRIEF.md
# Up/Down PWM Timer Channel

A single 16-bit timer channel for pulse-width modulation and edge timing. The counter runs as a rising sawtooth, a falling sawtooth, or a triangle that climbs to the period value and returns to zero. The count advances only on cycles where the prescaler tick input is high. A one-cycle flag marks each crest, where the period value is reached while counting up, and each trough, where zero is reached while counting down.

Two channel slots, A and B, each own an active compare register and a shadow register. In compare mode a slot drives its pin on a match: the pin goes low, goes high or toggles, as its action code selects. The shadow can be copied into the active register at the crest, at the trough, or at both. This lets the rising and falling halves of a triangle frame use different duty values. When no copy point is selected, the shadow acts as a second compare value. In capture mode a slot latches the counter on the selected pin edge instead. Slot A also feeds a complementary pair with a programmable dead time. Software pulses or an external trigger start, stop and clear the counter.

Top module: `updn_pwm_timer`

## Requirements
- R1: Reset is synchronous and active high. Afterwards the counter is 0, it counts up, it is stopped, both flags are 0, both compare registers are 0, and every pin output is 0.
- R2: The counter changes only on a cycle where `tick` is 1 and the channel is running. A clear is the one exception.
- R3: When `mode` is 0 (or 3), the counter counts up. On the advance from `period` it wraps to 0, and `ovf` is 1 for exactly the following cycle.
- R4: When `mode` is 1, the counter counts down. On the advance from 0 it reloads `period`, and `unf` is 1 for exactly the following cycle. `count_up` is 0 in this mode.
- R5: When `mode` is 2, the counter counts 0,1,…,`period`,`period`-1,…,0,1,… Leaving `period` pulses `ovf` and leaving 0 pulses `unf`. `count_up` shows the current direction.
- R6: Shadow-to-active copy happens on the advance that leaves the crest (`bufm` bit 0) and/or the trough (`bufm` bit 1). Compares from the next cycle on use the new value.
- R7: When `bufm` is 00, a counter value equal to the shadow register is a compare match, just as a match on the active register is.
- R8: A compare match is an advancing cycle on which the counter equals the compare value. It updates the pin on the next edge according to the action code: 00 hold, 01 low, 10 high, 11 toggle.
- R9: With `cap` set, the slot copies the counter into its active register on a pin edge: `cap_edge` bit 0 selects rising edges and bit 1 selects falling edges. The pin input is compared with its value one cycle earlier. Capture works while the counter is stopped, and compare matches do not change the pin output.
- R10: `pwm_hi` follows slot A's pin and `pwm_lo` follows its inverse. Each one falls on the edge after its source falls. Each one rises only after `dead` ticks have been counted with its source high, so the two are never high together.
- R11: The counter is stopped by `sw_stop`, or by `ext_trig` with `ext_act`=10. It is started by `sw_start`, or by `ext_trig` with `ext_act`=01. It is cleared by `sw_clear`, or by `ext_trig` with `ext_act`=11. Stop wins over start. A stop freezes the count on its own edge. A start takes effect from the next edge. A clear loads `period` in mode 1 and 0 in the other modes, and it sets the direction to up.
- R12: Write addresses are 0 for active A, 1 for active B, 2 for shadow A and 3 for shadow B. A capture wins over a write, and a write wins over a shadow copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaler count enable |
| mode | input | 2 | 0 up, 1 down, 2 triangle |
| period | input | 16 | Frame limit |
| dead | input | 16 | Dead time in ticks |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| sw_clear | input | 1 | Software clear pulse |
| ext_trig | input | 1 | External trigger pulse |
| ext_act | input | 2 | Trigger action: 01 start, 10 stop, 11 clear |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write value |
| pin_act_a | input | 2 | Match action, slot A |
| pin_act_b | input | 2 | Match action, slot B |
| bufm_a | input | 2 | Shadow copy points, slot A |
| bufm_b | input | 2 | Shadow copy points, slot B |
| cap_a | input | 1 | Capture mode, slot A |
| cap_b | input | 1 | Capture mode, slot B |
| cap_edge_a | input | 2 | Capture edges, slot A |
| cap_edge_b | input | 2 | Capture edges, slot B |
| pin_a_in | input | 1 | Pin A sample |
| pin_b_in | input | 1 | Pin B sample |
| cnt_o | output | 16 | Counter value |
| count_up | output | 1 | Current direction |
| running | output | 1 | Counter is running |
| ovf | output | 1 | Crest flag pulse |
| unf | output | 1 | Trough flag pulse |
| cmp_a_o | output | 16 | Active register A |
| cmp_b_o | output | 16 | Active register B |
| pin_a_out | output | 1 | Pin A drive |
| pin_b_out | output | 1 | Pin B drive |
| pwm_hi | output | 1 | Complementary high side |
| pwm_lo | output | 1 | Complementary low side |

## Verification
The counter's turnaround at the crest and the shadow copy into slot A's compare register fall on the same clock edge. The compare made on the very next edge must already see the new value. This is provoked with a triangle frame of period 4: the active value is 1, the shadow value is 3, and copy at the crest is selected. The pin must fall one cycle after the crest, when the count is 3 on the way down, not three cycles later at 1. Stop and start pulsed on the same edge form a second collision, judged by the channel staying stopped.

// File: rtl/updn_pwm_timer.sv
module updn_pwm_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] period,
  input  logic [W-1:0] dead,
  input  logic         sw_start,
  input  logic         sw_stop,
  input  logic         sw_clear,
  input  logic         ext_trig,
  input  logic [1:0]   ext_act,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   pin_act_a,
  input  logic [1:0]   pin_act_b,
  input  logic [1:0]   bufm_a,
  input  logic [1:0]   bufm_b,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [1:0]   cap_edge_a,
  input  logic [1:0]   cap_edge_b,
  input  logic         pin_a_in,
  input  logic         pin_b_in,
  output logic [W-1:0] cnt_o,
  output logic         count_up,
  output logic         running,
  output logic         ovf,
  output logic         unf,
  output logic [W-1:0] cmp_a_o,
  output logic [W-1:0] cmp_b_o,
  output logic         pin_a_out,
  output logic         pin_b_out,
  output logic         pwm_hi,
  output logic         pwm_lo
);
  localparam logic [1:0] MODE_DN  = 2'd1;
  localparam logic [1:0] MODE_TRI = 2'd2;

  logic [W-1:0] cnt, dly_hi, dly_lo;
  logic         dir;
  logic [W-1:0] cmp_q [2];
  logic [W-1:0] shd_q [2];
  logic [1:0]   act_c [2];
  logic [1:0]   edg_c [2];
  logic [1:0]   bm_c  [2];
  logic [1:0]   pin_q, pin_prev, pin_in, cap_on, hit, xfer, match;

  assign act_c[0] = pin_act_a;
  assign act_c[1] = pin_act_b;
  assign edg_c[0] = cap_edge_a;
  assign edg_c[1] = cap_edge_b;
  assign bm_c[0]  = bufm_a;
  assign bm_c[1]  = bufm_b;
  assign pin_in   = {pin_b_in, pin_a_in};
  assign cap_on   = {cap_b, cap_a};

  wire clr_now   = sw_clear | (ext_trig & (ext_act == 2'b11));
  wire stop_now  = sw_stop  | (ext_trig & (ext_act == 2'b10));
  wire start_now = sw_start | (ext_trig & (ext_act == 2'b01));

  assign count_up = (mode == MODE_TRI) ? dir : (mode != MODE_DN);
  wire adv    = tick & running & ~stop_now & ~clr_now;
  wire crest  = adv & count_up & (cnt == period);
  wire trough = adv & ~count_up & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; dir <= 1'b1; running <= 1'b0; ovf <= 1'b0; unf <= 1'b0;
    end else begin
      ovf <= crest;
      unf <= trough;
      if (stop_now)       running <= 1'b0;
      else if (start_now) running <= 1'b1;
      if (clr_now) begin
        cnt <= (mode == MODE_DN) ? period : '0;
        dir <= 1'b1;
      end else if (crest) begin
        cnt <= (mode == MODE_TRI) ? cnt - 1'b1 : '0;
        if (mode == MODE_TRI) dir <= 1'b0;
      end else if (trough) begin
        cnt <= (mode == MODE_TRI) ? cnt + 1'b1 : period;
        dir <= 1'b1;
      end else if (adv) begin
        cnt <= count_up ? cnt + 1'b1 : cnt - 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      hit[i]   = cap_on[i] & ((edg_c[i][0] & pin_in[i] & ~pin_prev[i]) |
                              (edg_c[i][1] & ~pin_in[i] & pin_prev[i]));
      xfer[i]  = ~cap_on[i] & ((bm_c[i][0] & crest) | (bm_c[i][1] & trough));
      match[i] = ~cap_on[i] & adv &
                 ((cnt == cmp_q[i]) | ((bm_c[i] == 2'b00) & (cnt == shd_q[i])));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        cmp_q[i] <= '0; shd_q[i] <= '0; pin_q[i] <= 1'b0; pin_prev[i] <= 1'b0;
      end else begin
        pin_prev[i] <= pin_in[i];
        if (hit[i])                                    cmp_q[i] <= cnt;
        else if (wr_en && wr_addr == {1'b0, 1'(i)})    cmp_q[i] <= wr_data;
        else if (xfer[i])                              cmp_q[i] <= shd_q[i];
        if (wr_en && wr_addr == {1'b1, 1'(i)})         shd_q[i] <= wr_data;
        if (match[i]) begin
          case (act_c[i])
            2'b01:   pin_q[i] <= 1'b0;
            2'b10:   pin_q[i] <= 1'b1;
            2'b11:   pin_q[i] <= ~pin_q[i];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_hi <= 1'b0; pwm_lo <= 1'b0; dly_hi <= '0; dly_lo <= '0;
    end else begin
      if (!pin_q[0]) begin
        pwm_hi <= 1'b0; dly_hi <= '0;
      end else if (!pwm_hi) begin
        if (dly_hi >= dead) pwm_hi <= 1'b1;
        else if (tick)      dly_hi <= dly_hi + 1'b1;
      end
      if (pin_q[0]) begin
        pwm_lo <= 1'b0; dly_lo <= '0;
      end else if (!pwm_lo) begin
        if (dly_lo >= dead) pwm_lo <= 1'b1;
        else if (tick)      dly_lo <= dly_lo + 1'b1;
      end
    end
  end

  assign cnt_o     = cnt;
  assign cmp_a_o   = cmp_q[0];
  assign cmp_b_o   = cmp_q[1];
  assign pin_a_out = pin_q[0];
  assign pin_b_out = pin_q[1];
endmodule

// File: rtl/updn_pwm_timer_chk.sv
module updn_pwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] period,
  input logic         sw_clear,
  input logic         ext_trig,
  input logic [1:0]   ext_act,
  input logic [W-1:0] cnt_o,
  input logic         count_up,
  input logic         running,
  input logic         ovf,
  input logic         unf,
  input logic         pin_a_out,
  input logic         pwm_hi,
  input logic         pwm_lo
);
  wire any_clr = sw_clear | (ext_trig & (ext_act == 2'b11));

  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !any_clr) |=> $stable(cnt_o));

  // R11
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && !any_clr) |=> $stable(cnt_o));

  // R3
  ovf_at_crest_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ($past(cnt_o) == $past(period)) && $past(count_up));

  // R4
  unf_at_trough_chk: assert property (@(posedge clk) disable iff (rst)
    unf |-> ($past(cnt_o) == '0) && !$past(count_up));

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(pwm_hi && pwm_lo));

  // R10
  hi_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_hi) |-> $past(pin_a_out));

  // R10
  lo_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_lo) |-> !$past(pin_a_out));
endmodule

bind updn_pwm_timer updn_pwm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .period(period), .sw_clear(sw_clear),
  .ext_trig(ext_trig), .ext_act(ext_act), .cnt_o(cnt_o), .count_up(count_up),
  .running(running), .ovf(ovf), .unf(unf), .pin_a_out(pin_a_out),
  .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
);

// File: tb/updn_pwm_timer_tb_top.sv
`timescale 1ns/10ps
module updn_pwm_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [15:0] period = 16'd4;
  logic [15:0] dead = 16'd2;
  logic sw_start = 0, sw_stop = 0, sw_clear = 0, ext_trig = 0;
  logic [1:0] ext_act = 2'd0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0] pin_act_a = 0, pin_act_b = 0, bufm_a = 0, bufm_b = 0;
  logic cap_a = 0, cap_b = 0;
  logic [1:0] cap_edge_a = 0, cap_edge_b = 0;
  logic pin_a_in = 0, pin_b_in = 0;
  logic [15:0] cnt_o, cmp_a_o, cmp_b_o;
  logic count_up, running, ovf, unf, pin_a_out, pin_b_out, pwm_hi, pwm_lo;

  always #10 clk = ~clk;

  updn_pwm_timer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .period(period), .dead(dead),
    .sw_start(sw_start), .sw_stop(sw_stop), .sw_clear(sw_clear),
    .ext_trig(ext_trig), .ext_act(ext_act), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_act_a(pin_act_a), .pin_act_b(pin_act_b),
    .bufm_a(bufm_a), .bufm_b(bufm_b), .cap_a(cap_a), .cap_b(cap_b),
    .cap_edge_a(cap_edge_a), .cap_edge_b(cap_edge_b),
    .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .cnt_o(cnt_o), .count_up(count_up),
    .running(running), .ovf(ovf), .unf(unf), .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o),
    .pin_a_out(pin_a_out), .pin_b_out(pin_b_out), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  localparam int S_CNT = 0, S_RUN = 1, S_UP = 2, S_OVF = 3, S_UNF = 4, S_CA = 5,
                 S_CB = 6, S_PA = 7, S_PB = 8, S_HI = 9, S_LO = 10;

  typedef struct {
    string       req;
    int          sig;
    logic [15:0] exp;
  } sb_item_t;

  sb_item_t sb_q [$];
  sb_item_t cur;
  event flush_ev;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [15:0] sample(input int s);
    case (s)
      S_CNT: return cnt_o;
      S_RUN: return {15'd0, running};
      S_UP:  return {15'd0, count_up};
      S_OVF: return {15'd0, ovf};
      S_UNF: return {15'd0, unf};
      S_CA:  return cmp_a_o;
      S_CB:  return cmp_b_o;
      S_PA:  return {15'd0, pin_a_out};
      S_PB:  return {15'd0, pin_b_out};
      S_HI:  return {15'd0, pwm_hi};
      default: return {15'd0, pwm_lo};
    endcase
  endfunction

  always @(flush_ev) begin
    while (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      n_checks++;
      if (sample(cur.sig) !== cur.exp) begin
        n_fail++;
        $display("FAIL %s sig%0d: got %0d expected %0d", cur.req, cur.sig,
                 sample(cur.sig), cur.exp);
      end
    end
  end

  task automatic chk(input string req, input int sig, input logic [15:0] exp);
    sb_item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    sb_q.push_back(it);
    -> flush_ev;
    #0.2;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic pulse(input bit st, input bit sp, input bit cl);
    sw_start = st; sw_stop = sp; sw_clear = cl;
    step(1);
    sw_start = 0; sw_stop = 0; sw_clear = 0;
  endtask

  task automatic ext_pulse(input logic [1:0] a);
    ext_act = a; ext_trig = 1;
    step(1);
    ext_trig = 0; ext_act = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step(1);
    chk("R1", S_CNT, 0); chk("R1", S_RUN, 0); chk("R1", S_UP, 1);
    chk("R1", S_HI, 0);  chk("R1", S_LO, 0);  chk("R1", S_OVF, 0);

    // saw up, period 4
    pulse(1, 0, 0);
    chk("R11", S_RUN, 1); chk("R3", S_CNT, 0);
    step(4); chk("R3", S_CNT, 4); chk("R3", S_OVF, 0);
    step(1); chk("R3", S_CNT, 0); chk("R3", S_OVF, 1);
    step(1); chk("R3", S_CNT, 1); chk("R3", S_OVF, 0);

    // tick gating
    tick = 0; step(3); chk("R2", S_CNT, 1);
    tick = 1; step(1); chk("R2", S_CNT, 2);

    // software stop / clear, stop wins over start
    pulse(0, 1, 0); chk("R11", S_CNT, 2); chk("R11", S_RUN, 0);
    step(2); chk("R2", S_CNT, 2);
    pulse(1, 1, 0); chk("R11", S_RUN, 0);
    pulse(0, 0, 1); chk("R11", S_CNT, 0);

    // saw down
    mode = 2'd1;
    pulse(1, 0, 1); chk("R11", S_CNT, 4); chk("R4", S_UP, 0); chk("R11", S_RUN, 1);
    step(4); chk("R4", S_CNT, 0); chk("R4", S_UNF, 0);
    step(1); chk("R4", S_CNT, 4); chk("R4", S_UNF, 1);
    step(1); chk("R4", S_CNT, 3); chk("R4", S_UNF, 0);

    // external trigger
    ext_pulse(2'b10); chk("R11", S_RUN, 0); chk("R11", S_CNT, 3);
    step(1); chk("R11", S_CNT, 3);
    ext_pulse(2'b01); chk("R11", S_RUN, 1); chk("R11", S_CNT, 3);
    step(1); chk("R11", S_CNT, 2);
    ext_pulse(2'b11); chk("R11", S_CNT, 4); chk("R11", S_RUN, 1);
    pulse(0, 1, 0); chk("R11", S_CNT, 4);

    // triangle, crest copy, toggle, dead time
    mode = 2'd2; bufm_a = 2'b01; pin_act_a = 2'b11;
    wr(2'd0, 16'd1); wr(2'd2, 16'd3); chk("R12", S_CA, 1);
    pulse(1, 0, 1); chk("R5", S_CNT, 0); chk("R5", S_UP, 1);
    step(1); chk("R5", S_CNT, 1); chk("R8", S_PA, 0);
    step(1); chk("R5", S_CNT, 2); chk("R8", S_PA, 1); chk("R10", S_LO, 1); chk("R10", S_HI, 0);
    step(1); chk("R10", S_LO, 0); chk("R10", S_HI, 0);
    step(1); chk("R5", S_CNT, 4); chk("R10", S_HI, 0); chk("R5", S_UP, 1);
    step(1); chk("R5", S_CNT, 3); chk("R5", S_OVF, 1); chk("R5", S_UP, 0);
             chk("R6", S_CA, 3);  chk("R10", S_HI, 1); chk("R8", S_PA, 1);
    step(1); chk("R6", S_PA, 0);
    step(1); chk("R10", S_HI, 0); chk("R10", S_LO, 0);
    step(1); chk("R5", S_CNT, 0); chk("R10", S_LO, 0);
    step(1); chk("R5", S_CNT, 1); chk("R5", S_UNF, 1); chk("R10", S_LO, 1); chk("R5", S_UP, 1);
    pulse(0, 1, 0);

    // shadow as extra compare, action codes
    mode = 2'd0; period = 16'd100; bufm_a = 2'b00; pin_act_a = 2'b11;
    wr(2'd0, 16'd2); wr(2'd2, 16'd5);
    pulse(1, 0, 1); chk("R7", S_CNT, 0);
    step(2); chk("R8", S_PA, 0);
    step(1); chk("R8", S_PA, 1);
    step(2); chk("R7", S_PA, 1);
    step(1); chk("R7", S_PA, 0);
    pulse(0, 1, 0);
    pin_act_a = 2'b10;
    pulse(1, 0, 1);
    step(3); chk("R8", S_PA, 1);
    step(3); chk("R8", S_PA, 1);
    pulse(0, 1, 0);
    pin_act_a = 2'b01;
    pulse(1, 0, 1);
    step(2); chk("R8", S_PA, 1);
    step(1); chk("R8", S_PA, 0);
    step(3); chk("R8", S_PA, 0);
    pulse(0, 1, 0);

    // capture on slot B
    pin_act_b = 2'b11; cap_b = 1; cap_edge_b = 2'b01;
    pulse(1, 0, 1);
    step(7); chk("R9", S_CNT, 7);
    pulse(0, 1, 0); chk("R9", S_CNT, 7);
    pin_b_in = 1; step(1); chk("R9", S_CB, 7);
    pulse(1, 0, 0);
    step(3); chk("R9", S_CNT, 10); chk("R9", S_PB, 0);
    pulse(0, 1, 0);
    pin_b_in = 0; step(1); chk("R9", S_CB, 7);
    cap_edge_b = 2'b11;
    pin_b_in = 1; step(1); chk("R9", S_CB, 10);
    pulse(1, 0, 0);
    step(2);
    pulse(0, 1, 0); chk("R9", S_CNT, 12);
    pin_b_in = 0; step(1); chk("R9", S_CB, 12);
    wr_en = 1; wr_addr = 2'd1; wr_data = 16'd55; pin_b_in = 1;
    step(1); wr_en = 0;
    chk("R12", S_CB, 12);

    -> flush_ev;
    #1;
    done = 1;
    summary();
    $finish;
  end
endmodule